// File: doc/BRIEF.md
# Dual-Port Shift Register Latch Router

This block connects two parallel shift ports to three banks of shift-register latches: a grayscale bank, a brightness bank and a dot-correction bank. Port A is 10 bits wide and port B is 6 bits wide. Each port has its own shift clock and its own latch strobe. Each port loads one word per active shift-clock edge into a 16-stage chain. The oldest stage appears on the port's data output, so several devices can be cascaded. A rising edge on a strobe copies the whole chain into a parallel latch. The latch stays steady while the next frame is shifted in.

A 2-bit select input picks the route. The select is sampled into a small route state machine. It is only sampled while port A's shift clock rests at its inactive level, so a route never changes in the middle of a shift pulse. A polarity input chooses which clock edge is active for both ports.

The route state machine has four states:
- `RT_GRAY` (select 00): A drives grayscale, B drives dot correction.
- `RT_BRIGHT` (select 01): A drives brightness, B drives dot correction.
- `RT_DOTA` (select 10): A's low six bits drive dot correction and B is disconnected.
- `RT_HOLD` (select 11): everything is inhibited.

The machine has three kinds of transition:
- `T_FOLLOW`: the state loads the decoded select whenever port A's clock is inactive.
- `T_FREEZE`: the state is kept while port A's clock is at its active level.
- `T_RESET`: reset forces `RT_GRAY`.

Top module: `srl_route_top`

## Requirements
- R1: Port A shifts one 10-bit word into its routed chain per active edge of `a_sclk`. Each chain has 16 stages, with stage 0 the newest word. In routes 00 and 01, `a_dout` shows stage 15 of the routed chain.
- R2: With select 00, port A words enter the grayscale chain and port B words enter the 6-bit dot-correction chain. `b_dout` shows dot-correction stage 15.
- R3: With select 01, port A words enter the brightness chain and port B words enter the dot-correction chain. The grayscale chain and its latch are left unchanged.
- R4: With select 10, bits 5..0 of port A words enter the dot-correction chain. In this route:
  - `a_dout[5:0]` shows dot-correction stage 15 and `a_dout[9:6]` is 0.
  - `b_dout` still shows dot-correction stage 15.
  - Port B clock, data and strobe have no effect.
  - `a_strobe` latches the dot-correction chain.
- R5: With select 11, no chain shifts and no latch loads. `a_dout` and `b_dout` are 0.
- R6: A rising edge of a port's strobe copies the chain routed to that port into its latch output. Stage k of a chain sits at bits [k*W +: W] of the latch output, where W is the chain's word width. Latch outputs change at no other time.
- R7: When `pol` is 1, the rising edge of a shift clock is active and its inactive level is low. When `pol` is 0, the falling edge is active and its inactive level is high. The opposite edge never shifts.
- R8: A new select value takes effect only after `a_sclk` has been sampled at its inactive level. The select must be held steady while `a_sclk` is at its active level.
- R9: After reset, all chains and latches are 0 and the route is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| pol | input | 1 | Shift-clock polarity: 1 means the rising edge is active |
| sel | input | 2 | Route select (00 gray/dot, 01 bright/dot, 10 dot from A, 11 inhibit) |
| a_data | input | 10 | Port A parallel data |
| a_sclk | input | 1 | Port A shift clock |
| a_strobe | input | 1 | Port A latch strobe (rising edge) |
| a_dout | output | 10 | Port A cascade output |
| b_data | input | 6 | Port B parallel data |
| b_sclk | input | 1 | Port B shift clock |
| b_strobe | input | 1 | Port B latch strobe (rising edge) |
| b_dout | output | 6 | Port B cascade output |
| gray_q | output | 160 | Grayscale latch, 16 x 10 bits |
| bright_q | output | 160 | Brightness latch, 16 x 10 bits |
| dot_q | output | 96 | Dot-correction latch, 16 x 6 bits |

## Verification
The assertions take for granted that `sel` never moves while `a_sclk` sits at its active level. They also assume that `pol` only changes together with both shift clocks, so the normalised clock levels stay inactive when it does. The stimulus changes `sel` and `pol` only at system-clock falling edges while both shift clocks rest inactive. It then waits three cycles before the next pulse, and each shift or strobe pulse is held for two system cycles per level. The bench sweeps all four routes under both polarities with arithmetic word patterns, and checks every cascade output and latch against an array model.

// File: rtl/srl_route_pkg.sv
package srl_route_pkg;

    typedef enum logic [1:0] {
        RT_GRAY   = 2'b00,
        RT_BRIGHT = 2'b01,
        RT_DOTA   = 2'b10,
        RT_HOLD   = 2'b11
    } route_e;

    function automatic route_e route_of(input logic [1:0] code);
        route_e r;
        unique case (code)
            2'b00:   r = RT_GRAY;
            2'b01:   r = RT_BRIGHT;
            2'b10:   r = RT_DOTA;
            default: r = RT_HOLD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/srl_edge_detect.sv
module srl_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pol,
    input  logic sig,
    output logic act_lvl,
    output logic act_edge
);
    logic prev_q;

    assign act_lvl = pol ? sig : ~sig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= act_lvl;
        end
    end

    assign act_edge = act_lvl & ~prev_q;
endmodule

// File: rtl/srl_route_fsm.sv
module srl_route_fsm
    import srl_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       a_act_lvl,
    output route_e     route,
    output logic       a_to_gray,
    output logic       a_to_bright,
    output logic       a_to_dot,
    output logic       b_to_dot
);
    route_e state_q, state_d;

    // T_RESET forces RT_GRAY.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RT_GRAY;
        end else begin
            state_q <= state_d;
        end
    end

    // T_FREEZE while A clock is active, T_FOLLOW otherwise.
    always_comb begin
        if (a_act_lvl) begin
            state_d = state_q;
        end else begin
            state_d = route_of(sel);
        end
    end

    always_comb begin
        a_to_gray   = 1'b0;
        a_to_bright = 1'b0;
        a_to_dot    = 1'b0;
        b_to_dot    = 1'b0;
        unique case (state_q)
            RT_GRAY: begin
                a_to_gray = 1'b1;
                b_to_dot  = 1'b1;
            end
            RT_BRIGHT: begin
                a_to_bright = 1'b1;
                b_to_dot    = 1'b1;
            end
            RT_DOTA: begin
                a_to_dot = 1'b1;
            end
            RT_HOLD: begin
            end
        endcase
    end

    assign route = state_q;
endmodule

// File: rtl/srl_chain.sv
module srl_chain #(
    parameter int W     = 10,
    parameter int DEPTH = 16,
    localparam int FLAT = W * DEPTH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift,
    input  logic [W-1:0]    din,
    input  logic            grab,
    output logic [W-1:0]    tail,
    output logic [FLAT-1:0] latched
);
    logic [W-1:0]    stage_q [DEPTH];
    logic [FLAT-1:0] chain_flat;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[i] <= '0;
                end else if (shift) begin
                    stage_q[i] <= din;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[i] <= '0;
                end else if (shift) begin
                    stage_q[i] <= stage_q[i-1];
                end
            end
        end
        assign chain_flat[i*W +: W] = stage_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latched <= '0;
        end else if (grab) begin
            latched <= chain_flat;
        end
    end

    assign tail = stage_q[DEPTH-1];
endmodule

// File: rtl/srl_route_top.sv
module srl_route_top
    import srl_route_pkg::*;
#(
    parameter int A_W   = 10,
    parameter int B_W   = 6,
    parameter int DEPTH = 16,
    localparam int A_FLAT = A_W * DEPTH,
    localparam int B_FLAT = B_W * DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pol,
    input  logic [1:0]        sel,
    input  logic [A_W-1:0]    a_data,
    input  logic              a_sclk,
    input  logic              a_strobe,
    output logic [A_W-1:0]    a_dout,
    input  logic [B_W-1:0]    b_data,
    input  logic              b_sclk,
    input  logic              b_strobe,
    output logic [B_W-1:0]    b_dout,
    output logic [A_FLAT-1:0] gray_q,
    output logic [A_FLAT-1:0] bright_q,
    output logic [B_FLAT-1:0] dot_q
);
    logic   a_act, a_edge, b_act, b_edge;
    logic   a_lat_lvl, a_lat_edge, b_lat_lvl, b_lat_edge;
    route_e route;
    logic   a_to_gray, a_to_bright, a_to_dot, b_to_dot;
    logic [A_W-1:0] gray_tail, bright_tail;
    logic [B_W-1:0] dot_tail, dot_din;
    logic dot_shift, dot_grab;

    srl_edge_detect u_a_clk (.clk(clk), .rst_n(rst_n), .pol(pol),  .sig(a_sclk),
                             .act_lvl(a_act), .act_edge(a_edge));
    srl_edge_detect u_b_clk (.clk(clk), .rst_n(rst_n), .pol(pol),  .sig(b_sclk),
                             .act_lvl(b_act), .act_edge(b_edge));
    srl_edge_detect u_a_lat (.clk(clk), .rst_n(rst_n), .pol(1'b1), .sig(a_strobe),
                             .act_lvl(a_lat_lvl), .act_edge(a_lat_edge));
    srl_edge_detect u_b_lat (.clk(clk), .rst_n(rst_n), .pol(1'b1), .sig(b_strobe),
                             .act_lvl(b_lat_lvl), .act_edge(b_lat_edge));

    srl_route_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sel(sel), .a_act_lvl(a_act), .route(route),
        .a_to_gray(a_to_gray), .a_to_bright(a_to_bright),
        .a_to_dot(a_to_dot), .b_to_dot(b_to_dot)
    );

    srl_chain #(.W(A_W), .DEPTH(DEPTH)) u_gray (
        .clk(clk), .rst_n(rst_n), .shift(a_to_gray & a_edge), .din(a_data),
        .grab(a_to_gray & a_lat_edge), .tail(gray_tail), .latched(gray_q)
    );

    srl_chain #(.W(A_W), .DEPTH(DEPTH)) u_bright (
        .clk(clk), .rst_n(rst_n), .shift(a_to_bright & a_edge), .din(a_data),
        .grab(a_to_bright & a_lat_edge), .tail(bright_tail), .latched(bright_q)
    );

    assign dot_din   = a_to_dot ? a_data[B_W-1:0] : b_data;
    assign dot_shift = (a_to_dot & a_edge) | (b_to_dot & b_edge);
    assign dot_grab  = (a_to_dot & a_lat_edge) | (b_to_dot & b_lat_edge);

    srl_chain #(.W(B_W), .DEPTH(DEPTH)) u_dot (
        .clk(clk), .rst_n(rst_n), .shift(dot_shift), .din(dot_din),
        .grab(dot_grab), .tail(dot_tail), .latched(dot_q)
    );

    always_comb begin
        a_dout = '0;
        unique case (route)
            RT_GRAY:   a_dout = gray_tail;
            RT_BRIGHT: a_dout = bright_tail;
            RT_DOTA:   a_dout = {{(A_W-B_W){1'b0}}, dot_tail};
            RT_HOLD:   a_dout = '0;
        endcase
    end

    assign b_dout = (route == RT_HOLD) ? '0 : dot_tail;
endmodule

// File: rtl/srl_route_chk.sv
module srl_route_chk
    import srl_route_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   sel,
    input logic         a_act,
    input logic         a_edge,
    input logic         a_lat_edge,
    input logic         b_lat_edge,
    input route_e       route,
    input logic [9:0]   a_dout,
    input logic [5:0]   b_dout,
    input logic [9:0]   gray_tail,
    input logic [9:0]   bright_tail,
    input logic [5:0]   dot_tail,
    input logic [159:0] gray_q,
    input logic [159:0] bright_q,
    input logic [95:0]  dot_q
);
    assert_hold_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        route == RT_HOLD |=> $stable(gray_q) && $stable(bright_q) && $stable(dot_q)
            && $stable(gray_tail) && $stable(bright_tail) && $stable(dot_tail));

    assert_hold_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        route == RT_HOLD |-> a_dout == '0 && b_dout == '0);

    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        route == RT_DOTA |-> a_dout[9:6] == 4'b0000);

    assert_b_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (route == RT_DOTA && !a_edge) |=> $stable(dot_tail));

    assert_gray_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        route == RT_BRIGHT |=> $stable(gray_tail) && $stable(gray_q));

    assert_latch_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_lat_edge && !b_lat_edge) |=> $stable(gray_q) && $stable(bright_q) && $stable(dot_q));

    assert_route_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        a_act |=> $stable(route));

    assert_sel_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_act && $past(a_act)) |-> $stable(sel));
endmodule

bind srl_route_top srl_route_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .a_act(a_act), .a_edge(a_edge),
    .a_lat_edge(a_lat_edge), .b_lat_edge(b_lat_edge), .route(route),
    .a_dout(a_dout), .b_dout(b_dout), .gray_tail(gray_tail),
    .bright_tail(bright_tail), .dot_tail(dot_tail),
    .gray_q(gray_q), .bright_q(bright_q), .dot_q(dot_q)
);

// File: tb/test_srl_route_top.sv
module test_srl_route_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst_n, pol, a_sclk, a_strobe, b_sclk, b_strobe;
    logic [1:0]   sel;
    logic [9:0]   a_data, a_dout;
    logic [5:0]   b_data, b_dout;
    logic [159:0] gray_q, bright_q;
    logic [95:0]  dot_q;

    srl_route_top i_srl_route_top (
        .clk(clk), .rst_n(rst_n), .pol(pol), .sel(sel),
        .a_data(a_data), .a_sclk(a_sclk), .a_strobe(a_strobe), .a_dout(a_dout),
        .b_data(b_data), .b_sclk(b_sclk), .b_strobe(b_strobe), .b_dout(b_dout),
        .gray_q(gray_q), .bright_q(bright_q), .dot_q(dot_q)
    );

    int n_vec = 0;
    int n_bad = 0;

    logic [9:0]   m_gray [16];
    logic [9:0]   m_bright [16];
    logic [5:0]   m_dot [16];
    logic [159:0] l_gray, l_bright;
    logic [95:0]  l_dot;

    task automatic chk(input string tag, input logic [159:0] got, input logic [159:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] s);
        case (s)
            2'b00:   return "R2 route00";
            2'b01:   return "R3 route01";
            2'b10:   return "R4 route10";
            default: return "R5 route11";
        endcase
    endfunction

    function automatic logic [9:0] exp_a_dout();
        case (sel)
            2'b00:   return m_gray[15];
            2'b01:   return m_bright[15];
            2'b10:   return {4'b0000, m_dot[15]};
            default: return 10'd0;
        endcase
    endfunction

    function automatic logic [5:0] exp_b_dout();
        return (sel == 2'b11) ? 6'd0 : m_dot[15];
    endfunction

    task automatic a_word(input logic [9:0] w);
        a_data = w;
        @(negedge clk) a_sclk = pol;
        repeat (2) @(negedge clk);
        a_sclk = ~pol;
        repeat (2) @(negedge clk);
        if (sel == 2'b00) begin
            for (int k = 15; k > 0; k--) m_gray[k] = m_gray[k-1];
            m_gray[0] = w;
        end else if (sel == 2'b01) begin
            for (int k = 15; k > 0; k--) m_bright[k] = m_bright[k-1];
            m_bright[0] = w;
        end else if (sel == 2'b10) begin
            for (int k = 15; k > 0; k--) m_dot[k] = m_dot[k-1];
            m_dot[0] = w[5:0];
        end
    endtask

    task automatic b_word(input logic [5:0] w);
        b_data = w;
        @(negedge clk) b_sclk = pol;
        repeat (2) @(negedge clk);
        b_sclk = ~pol;
        repeat (2) @(negedge clk);
        if (sel == 2'b00 || sel == 2'b01) begin
            for (int k = 15; k > 0; k--) m_dot[k] = m_dot[k-1];
            m_dot[0] = w;
        end
    endtask

    task automatic strobe_a();
        @(negedge clk) a_strobe = 1'b1;
        repeat (2) @(negedge clk);
        a_strobe = 1'b0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 16; k++) begin
            if (sel == 2'b00) l_gray[k*10 +: 10] = m_gray[k];
            if (sel == 2'b01) l_bright[k*10 +: 10] = m_bright[k];
            if (sel == 2'b10) l_dot[k*6 +: 6] = m_dot[k];
        end
    endtask

    task automatic strobe_b();
        @(negedge clk) b_strobe = 1'b1;
        repeat (2) @(negedge clk);
        b_strobe = 1'b0;
        repeat (2) @(negedge clk);
        if (sel == 2'b00 || sel == 2'b01)
            for (int k = 0; k < 16; k++) l_dot[k*6 +: 6] = m_dot[k];
    endtask

    task automatic check_latches(input string tag);
        chk({tag, " R6 gray latch"}, gray_q, l_gray);
        chk({tag, " R6 bright latch"}, bright_q, l_bright);
        chk({tag, " R6 dot latch"}, {64'd0, dot_q}, {64'd0, l_dot});
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pol = 1'b1; sel = 2'b00;
        a_sclk = 1'b0; b_sclk = 1'b0; a_strobe = 1'b0; b_strobe = 1'b0;
        a_data = '0; b_data = '0;
        for (int k = 0; k < 16; k++) begin
            m_gray[k] = '0; m_bright[k] = '0; m_dot[k] = '0;
        end
        l_gray = '0; l_bright = '0; l_dot = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 reset a_dout", {150'd0, a_dout}, 160'd0);
        chk("R9 reset b_dout", {154'd0, b_dout}, 160'd0);
        check_latches("R9 reset");

        for (int p = 1; p >= 0; p--) begin
            @(negedge clk);
            pol = p[0]; a_sclk = ~p[0]; b_sclk = ~p[0];
            repeat (3) @(negedge clk);
            for (int s = 0; s < 4; s++) begin
                sel = s[1:0];
                repeat (3) @(negedge clk);
                chk({tag_of(sel), " R8 route switch a_dout"}, {150'd0, a_dout}, {150'd0, exp_a_dout()});
                for (int k = 0; k < 16; k++) begin
                    a_word(10'((s * 97 + k * 53 + p * 211 + 5) & 10'h3FF));
                    chk({tag_of(sel), (p == 0) ? " R7 fall R1 a_dout" : " R7 rise R1 a_dout"},
                        {150'd0, a_dout}, {150'd0, exp_a_dout()});
                    b_word(6'((k * 11 + s * 5 + p * 29 + 3) & 6'h3F));
                    chk({tag_of(sel), " b_dout"}, {154'd0, b_dout}, {154'd0, exp_b_dout()});
                end
                strobe_a();
                check_latches({tag_of(sel), " after a_strobe"});
                strobe_b();
                check_latches({tag_of(sel), " after b_strobe"});
            end
        end

        sel = 2'b00;
        repeat (3) @(negedge clk);
        strobe_a();
        check_latches("R2 final gray latch");

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule